// File: doc/BRIEF.md
# DisplayPort Link Training Sequencer

This block brings a DisplayPort main link from idle to a trained, video-ready state. A capability front end supplies what the sink reported: link rate code, lane count, spread-spectrum support and enhanced-framing support. On a start pulse the sequencer latches these values and issues a fixed series of DPCD writes through an AUX request/acknowledge port. It then runs clock recovery and, only if that passes, channel equalization. While each phase runs it drives the local transmitter's training-pattern select.

Lane status comes from the PHY side as plain per-lane inputs, so the sequencer needs no AUX reads while it polls. Training only counts as finished when the pattern has been removed from both ends of the link and the sink confirms that it is in sync. Any failure path also turns the pattern off, so the link is never left carrying training symbols in place of video.

Top module: `lt_train_seq`

## Requirements
- R1: After reset, `aux_req_o`, `done_o` and `fail_o` are low and `tx_tps_o` is 0 (no pattern).
- R2: An accepted start issues these AUX writes in this order, each of one byte: DPCD 0x100 = rate code, 0x101 = lane count, 0x107 = downspread control, 0x108 = 0x01 (ANSI 8B/10B coding).
- R3: Bit 7 of the 0x101 byte is set exactly when the sink supports enhanced framing; bit 4 of the 0x107 byte is set exactly when the sink supports SSC. Lane count occupies bits 4:0.
- R4: Clock recovery sets `tx_tps_o` to 1, writes 0x21 to DPCD 0x102 (pattern 1, scrambling off), and passes only when every active lane (index below the lane count) reports CR done. Status on inactive lanes is ignored.
- R5: Equalization starts only after clock recovery passes. It sets `tx_tps_o` to 2, writes 0x22 to DPCD 0x102, and passes only when every active lane reports both EQ done and symbol lock and inter-lane alignment is reported.
- R6: Each phase polls status at most MAX_TRIES (5) times, with wait_cycles_i+1 cycles between polls. When the limit is used up, `tx_tps_o` returns to 0, 0x00 is written to DPCD 0x102 and `fail_o` is raised.
- R7: After equalization passes, `tx_tps_o` returns to 0, then 0x00 is written to DPCD 0x102, then DPCD 0x205 is read. `done_o` rises only if bit 0 of that byte (in sync) is set; otherwise `fail_o` rises.
- R8: `done_o` and `fail_o` are never high together. Either one holds until the next start. A start pulse during training is ignored.
- R9: An AUX request stays high, with address and data stable, until `aux_ack_i` is seen.
- R10: Capability inputs are latched at start; changing them during training does not alter the bytes written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start training (pulse) |
| cap_rate_i | input | 8 | Sink link rate code (0x0A = 2.7 Gbps) |
| cap_lanes_i | input | 3 | Sink lane count (1, 2 or 4) |
| cap_ssc_i | input | 1 | Sink supports downspread |
| cap_enh_i | input | 1 | Sink supports enhanced framing |
| wait_cycles_i | input | 16 | Cycles between status polls, minus one |
| lane_cr_done_i | input | 4 | Per-lane clock recovery done |
| lane_eq_done_i | input | 4 | Per-lane channel equalization done |
| lane_sym_lock_i | input | 4 | Per-lane symbol lock |
| lane_align_i | input | 1 | Inter-lane alignment done |
| aux_req_o | output | 1 | AUX transaction request |
| aux_wr_o | output | 1 | 1 = write, 0 = read |
| aux_addr_o | output | 20 | DPCD address |
| aux_len_o | output | 4 | Byte count |
| aux_wdata_o | output | 8 | Write byte |
| aux_ack_i | input | 1 | AUX transaction complete |
| aux_rdata_i | input | 8 | Read byte, valid with ack |
| tx_tps_o | output | 2 | Local pattern select: 0 off, 1 pattern 1, 2 pattern 2 |
| done_o | output | 1 | Link trained and sink in sync |
| fail_o | output | 1 | Training failed |

## Verification
A stuck or mis-sequenced state shows at the AUX port within one transaction: a missing, reordered or wrongly encoded configuration byte, or a 0x102 write whose value disagrees with `tx_tps_o`. A wrong retry counter or lane mask shows as the time spent with a given pattern active, which falls outside the window of five poll intervals, or as a pass or fail that the lane inputs do not justify. A skipped pattern-off or sync check shows as `done_o` rising without the final 0x102 write and 0x205 read before it.

// File: rtl/lt_pkg.sv
package lt_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_BW, S_LC, S_DS, S_CODE,
    S_CR_PAT, S_CR_POLL, S_EQ_PAT, S_EQ_POLL,
    S_OFF_PAT, S_STAT, S_FAIL_OFF, S_DONE, S_FAIL
  } lt_state_e;

  localparam logic [19:0] DPCD_BW_SET    = 20'h00100;
  localparam logic [19:0] DPCD_LANE_SET  = 20'h00101;
  localparam logic [19:0] DPCD_PAT_SET   = 20'h00102;
  localparam logic [19:0] DPCD_SPREAD    = 20'h00107;
  localparam logic [19:0] DPCD_CODING    = 20'h00108;
  localparam logic [19:0] DPCD_SINK_STAT = 20'h00205;

  localparam logic [1:0] TPS_OFF = 2'd0;
  localparam logic [1:0] TPS_1   = 2'd1;
  localparam logic [1:0] TPS_2   = 2'd2;

  localparam logic [7:0] PAT1_NOSCR = 8'h21;
  localparam logic [7:0] PAT2_NOSCR = 8'h22;
endpackage

// File: rtl/lt_wait_timer.sv
module lt_wait_timer #(
  parameter int unsigned WAIT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] count_i,
  output logic              expired_o
);
  logic [WAIT_W-1:0] cnt_q;
  logic              run_q;

  assign expired_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= count_i;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/lt_lane_eval.sv
module lt_lane_eval #(
  parameter int unsigned NUM_LANES = 4,
  localparam int unsigned LCNT_W   = $clog2(NUM_LANES + 1)
) (
  input  logic [LCNT_W-1:0]    lanes_i,
  input  logic [NUM_LANES-1:0] cr_done_i,
  input  logic [NUM_LANES-1:0] eq_done_i,
  input  logic [NUM_LANES-1:0] sym_lock_i,
  input  logic                 align_i,
  output logic                 cr_ok_o,
  output logic                 eq_ok_o
);
  logic [NUM_LANES-1:0] cr_ln, eq_ln;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic active;
    assign active   = (LCNT_W'(l) < lanes_i);
    assign cr_ln[l] = cr_done_i[l] | ~active;
    assign eq_ln[l] = (eq_done_i[l] & sym_lock_i[l]) | ~active;
  end

  assign cr_ok_o = &cr_ln;
  assign eq_ok_o = (&eq_ln) & align_i;
endmodule

// File: rtl/lt_train_seq.sv
module lt_train_seq
  import lt_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned WAIT_W    = 16,
  parameter int unsigned MAX_TRIES = 5,
  localparam int unsigned LCNT_W   = $clog2(NUM_LANES + 1),
  localparam int unsigned TRY_W    = $clog2(MAX_TRIES + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [7:0]           cap_rate_i,
  input  logic [LCNT_W-1:0]    cap_lanes_i,
  input  logic                 cap_ssc_i,
  input  logic                 cap_enh_i,
  input  logic [WAIT_W-1:0]    wait_cycles_i,
  input  logic [NUM_LANES-1:0] lane_cr_done_i,
  input  logic [NUM_LANES-1:0] lane_eq_done_i,
  input  logic [NUM_LANES-1:0] lane_sym_lock_i,
  input  logic                 lane_align_i,
  output logic                 aux_req_o,
  output logic                 aux_wr_o,
  output logic [19:0]          aux_addr_o,
  output logic [3:0]           aux_len_o,
  output logic [7:0]           aux_wdata_o,
  input  logic                 aux_ack_i,
  input  logic [7:0]           aux_rdata_i,
  output logic [1:0]           tx_tps_o,
  output logic                 done_o,
  output logic                 fail_o
);
  lt_state_e st_q, st_d;

  logic [7:0]        rate_q;
  logic [LCNT_W-1:0] lanes_q;
  logic              ssc_q, enh_q;
  logic [TRY_W-1:0]  tries_q;
  logic              tries_clr, tries_inc;
  logic              tmr_load, tmr_exp;
  logic              cr_ok, eq_ok;
  logic              idle_like;

  assign idle_like = (st_q == S_IDLE) || (st_q == S_DONE) || (st_q == S_FAIL);

  lt_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .count_i   (wait_cycles_i),
    .expired_o (tmr_exp)
  );

  lt_lane_eval #(.NUM_LANES(NUM_LANES)) u_eval (
    .lanes_i    (lanes_q),
    .cr_done_i  (lane_cr_done_i),
    .eq_done_i  (lane_eq_done_i),
    .sym_lock_i (lane_sym_lock_i),
    .align_i    (lane_align_i),
    .cr_ok_o    (cr_ok),
    .eq_ok_o    (eq_ok)
  );

  assign aux_len_o = 4'd1;

  always_comb begin
    st_d        = st_q;
    aux_req_o   = 1'b0;
    aux_wr_o    = 1'b1;
    aux_addr_o  = '0;
    aux_wdata_o = '0;
    tmr_load    = 1'b0;
    tries_clr   = 1'b0;
    tries_inc   = 1'b0;
    case (st_q)
      S_IDLE, S_DONE, S_FAIL: if (start_i) st_d = S_BW;
      S_BW: begin
        aux_req_o = 1'b1; aux_addr_o = DPCD_BW_SET; aux_wdata_o = rate_q;
        if (aux_ack_i) st_d = S_LC;
      end
      S_LC: begin
        aux_req_o = 1'b1; aux_addr_o = DPCD_LANE_SET;
        aux_wdata_o = {enh_q, 2'b00, 5'(lanes_q)};
        if (aux_ack_i) st_d = S_DS;
      end
      S_DS: begin
        aux_req_o = 1'b1; aux_addr_o = DPCD_SPREAD;
        aux_wdata_o = {3'b000, ssc_q, 4'h0};
        if (aux_ack_i) st_d = S_CODE;
      end
      S_CODE: begin
        aux_req_o = 1'b1; aux_addr_o = DPCD_CODING; aux_wdata_o = 8'h01;
        if (aux_ack_i) st_d = S_CR_PAT;
      end
      S_CR_PAT: begin
        aux_req_o = 1'b1; aux_addr_o = DPCD_PAT_SET; aux_wdata_o = PAT1_NOSCR;
        if (aux_ack_i) begin
          st_d = S_CR_POLL; tmr_load = 1'b1; tries_clr = 1'b1;
        end
      end
      S_CR_POLL: if (tmr_exp) begin
        if (cr_ok)                                  st_d = S_EQ_PAT;
        else if (tries_q == TRY_W'(MAX_TRIES - 1))  st_d = S_FAIL_OFF;
        else begin tries_inc = 1'b1; tmr_load = 1'b1; end
      end
      S_EQ_PAT: begin
        aux_req_o = 1'b1; aux_addr_o = DPCD_PAT_SET; aux_wdata_o = PAT2_NOSCR;
        if (aux_ack_i) begin
          st_d = S_EQ_POLL; tmr_load = 1'b1; tries_clr = 1'b1;
        end
      end
      S_EQ_POLL: if (tmr_exp) begin
        if (eq_ok)                                  st_d = S_OFF_PAT;
        else if (tries_q == TRY_W'(MAX_TRIES - 1))  st_d = S_FAIL_OFF;
        else begin tries_inc = 1'b1; tmr_load = 1'b1; end
      end
      S_OFF_PAT: begin
        aux_req_o = 1'b1; aux_addr_o = DPCD_PAT_SET; aux_wdata_o = 8'h00;
        if (aux_ack_i) st_d = S_STAT;
      end
      S_STAT: begin
        aux_req_o = 1'b1; aux_wr_o = 1'b0; aux_addr_o = DPCD_SINK_STAT;
        if (aux_ack_i) st_d = aux_rdata_i[0] ? S_DONE : S_FAIL;
      end
      S_FAIL_OFF: begin
        aux_req_o = 1'b1; aux_addr_o = DPCD_PAT_SET; aux_wdata_o = 8'h00;
        if (aux_ack_i) st_d = S_FAIL;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_comb begin
    case (st_q)
      S_CR_PAT, S_CR_POLL: tx_tps_o = TPS_1;
      S_EQ_PAT, S_EQ_POLL: tx_tps_o = TPS_2;
      default:             tx_tps_o = TPS_OFF;
    endcase
  end

  assign done_o = (st_q == S_DONE);
  assign fail_o = (st_q == S_FAIL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      rate_q  <= '0;
      lanes_q <= '0;
      ssc_q   <= 1'b0;
      enh_q   <= 1'b0;
      tries_q <= '0;
    end else begin
      st_q <= st_d;
      if (idle_like && start_i) begin
        rate_q  <= cap_rate_i;
        lanes_q <= cap_lanes_i;
        ssc_q   <= cap_ssc_i;
        enh_q   <= cap_enh_i;
      end
      if (tries_clr)      tries_q <= '0;
      else if (tries_inc) tries_q <= tries_q + 1'b1;
    end
  end
endmodule

// File: rtl/lt_train_seq_chk.sv
module lt_train_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        aux_req_o,
  input logic        aux_wr_o,
  input logic [19:0] aux_addr_o,
  input logic [7:0]  aux_wdata_o,
  input logic        aux_ack_i,
  input logic [1:0]  tx_tps_o,
  input logic        done_o,
  input logic        fail_o
);
  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_req_o && !aux_ack_i) |=>
      (aux_req_o && $stable(aux_addr_o) && $stable(aux_wdata_o) && $stable(aux_wr_o)));

  // R8
  excl_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));

  // R4
  pat1_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_req_o && aux_wr_o && aux_addr_o == 20'h00102 && aux_wdata_o == 8'h21)
      |-> (tx_tps_o == 2'd1));

  // R5
  pat_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_tps_o == 2'd2) |-> ($past(tx_tps_o) != 2'd0));

  // R7
  done_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(aux_req_o && !aux_wr_o && aux_addr_o == 20'h00205));

  // R6
  end_pat_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fail_o) |-> (tx_tps_o == 2'd0));
endmodule

bind lt_train_seq lt_train_seq_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .aux_req_o   (aux_req_o),
  .aux_wr_o    (aux_wr_o),
  .aux_addr_o  (aux_addr_o),
  .aux_wdata_o (aux_wdata_o),
  .aux_ack_i   (aux_ack_i),
  .tx_tps_o    (tx_tps_o),
  .done_o      (done_o),
  .fail_o      (fail_o)
);

// File: tb/lt_train_seq_tb_top.sv
module lt_train_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  cap_rate = 8'h0A;
  logic [2:0]  cap_lanes = 3'd2;
  logic        cap_ssc = 1'b0;
  logic        cap_enh = 1'b0;
  logic [15:0] wait_cyc = 16'd3;
  logic [3:0]  cr = 4'h0, eq = 4'h0, lk = 4'h0;
  logic        al = 1'b0;
  logic        req, wr, ack = 1'b0;
  logic [19:0] addr;
  logic [3:0]  len;
  logic [7:0]  wdata, rdata = 8'h00;
  logic [1:0]  tps;
  logic        done, fail;
  logic [7:0]  sink_stat = 8'h01;

  int n_chk = 0, n_bad = 0;
  int n_log = 0, dly = 0;
  logic [19:0] log_a [32];
  logic [7:0]  log_d [32];
  logic        log_w [32];
  logic [1:0]  log_t [32];
  int tps1_cyc, tps2_cyc;

  always #5 clk = ~clk;

  lt_train_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .cap_rate_i(cap_rate), .cap_lanes_i(cap_lanes), .cap_ssc_i(cap_ssc), .cap_enh_i(cap_enh),
    .wait_cycles_i(wait_cyc),
    .lane_cr_done_i(cr), .lane_eq_done_i(eq), .lane_sym_lock_i(lk), .lane_align_i(al),
    .aux_req_o(req), .aux_wr_o(wr), .aux_addr_o(addr), .aux_len_o(len), .aux_wdata_o(wdata),
    .aux_ack_i(ack), .aux_rdata_i(rdata),
    .tx_tps_o(tps), .done_o(done), .fail_o(fail)
  );

  // AUX responder: acks each request two negedges after it is first seen
  always @(negedge clk) begin
    if (ack) ack = 1'b0;
    else if (req) begin
      if (dly == 1) begin
        dly = 0;
        rdata = sink_stat;
        if (n_log < 32) begin
          log_a[n_log] = addr; log_d[n_log] = wdata;
          log_w[n_log] = wr;   log_t[n_log] = tps;
        end
        n_log++;
        ack = 1'b1;
      end else dly++;
    end else dly = 0;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic chk_log(input int i, input logic [19:0] a, input logic [7:0] d,
                         input string rq);
    chk(log_w[i] == 1'b1 && log_a[i] == a, rq, int'(log_a[i]), int'(a));
    chk(log_d[i] == d, rq, int'(log_d[i]), int'(d));
  endtask

  task automatic pulse_start();
    n_log = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_end(input string rq);
    bit seen;
    seen = 1'b0;
    tps1_cyc = 0; tps2_cyc = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (tps == 2'd1) tps1_cyc++;
      if (tps == 2'd2) tps2_cyc++;
      if (done || fail) seen = 1'b1;
    end
    chk(seen, {rq, " end reached"}, 0, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    // R1
    chk(req == 1'b0, "R1 req", req, 0);
    chk(tps == 2'd0, "R1 tps", tps, 0);
    chk(done == 1'b0 && fail == 1'b0, "R1 done/fail", {done, fail}, 0);
  endtask

  task automatic t_nominal();
    cap_rate = 8'h0A; cap_lanes = 3'd2; cap_ssc = 1'b1; cap_enh = 1'b1;
    wait_cyc = 16'd3; cr = 4'b0011; eq = 4'b0011; lk = 4'b0011; al = 1'b1;
    sink_stat = 8'h01;
    pulse_start();
    // R10: alter capabilities after start
    cap_rate = 8'h14; cap_enh = 1'b0; cap_ssc = 1'b0; cap_lanes = 3'd4;
    wait_end("R2 nominal");
    chk(n_log == 8, "R2 nominal transaction count", n_log, 8);
    chk_log(0, 20'h100, 8'h0A, "R10 rate byte latched");
    chk_log(1, 20'h101, 8'h82, "R3 lane set with enhanced framing");
    chk_log(2, 20'h107, 8'h10, "R3 downspread with SSC");
    chk_log(3, 20'h108, 8'h01, "R2 channel coding");
    chk_log(4, 20'h102, 8'h21, "R4 sink pattern 1");
    chk(log_t[4] == 2'd1, "R4 local pattern 1", log_t[4], 1);
    chk_log(5, 20'h102, 8'h22, "R5 sink pattern 2");
    chk(log_t[5] == 2'd2, "R5 local pattern 2", log_t[5], 2);
    chk_log(6, 20'h102, 8'h00, "R7 sink pattern off");
    chk(log_t[6] == 2'd0, "R7 local pattern off first", log_t[6], 0);
    chk(log_w[7] == 1'b0 && log_a[7] == 20'h205, "R7 sink status read", int'(log_a[7]), 'h205);
    chk(done && !fail, "R7 done", {done, fail}, 2);
    chk(len == 4'd1, "R2 byte count", len, 1);
    cap_rate = 8'h0A; cap_lanes = 3'd2;
  endtask

  task automatic t_one_lane();
    cap_rate = 8'h06; cap_lanes = 3'd1; cap_ssc = 1'b0; cap_enh = 1'b0;
    cr = 4'b0001; eq = 4'b0001; lk = 4'b0001; al = 1'b1;
    pulse_start();
    wait_end("R4 one lane");
    chk_log(0, 20'h100, 8'h06, "R2 rate byte");
    chk_log(1, 20'h101, 8'h01, "R3 lane set without enhanced framing");
    chk_log(2, 20'h107, 8'h00, "R3 downspread without SSC");
    chk(done && !fail, "R4 inactive lanes ignored", {done, fail}, 2);
  endtask

  task automatic t_cr_fail();
    cap_lanes = 3'd2; cap_enh = 1'b0; cap_ssc = 1'b0;
    wait_cyc = 16'd20; cr = 4'b1100; eq = 4'hF; lk = 4'hF; al = 1'b1;
    pulse_start();
    wait_end("R6 cr fail");
    chk(fail && !done, "R4 inactive lanes cannot pass CR", {done, fail}, 1);
    chk(tps2_cyc == 0, "R5 no EQ after CR failure", tps2_cyc, 0);
    chk(tps1_cyc >= 105 && tps1_cyc <= 113, "R6 five CR polls", tps1_cyc, 105);
    chk(n_log == 6, "R6 transaction count", n_log, 6);
    chk_log(5, 20'h102, 8'h00, "R6 sink pattern off on fail");
    chk(tps == 2'd0, "R6 local pattern off", tps, 0);
  endtask

  task automatic t_eq_fail();
    wait_cyc = 16'd20; cr = 4'b0011; eq = 4'b0011; lk = 4'b0001; al = 1'b1;
    pulse_start();
    wait_end("R6 eq fail");
    chk(fail && !done, "R5 missing symbol lock fails EQ", {done, fail}, 1);
    chk(tps2_cyc >= 105 && tps2_cyc <= 113, "R6 five EQ polls", tps2_cyc, 105);
    chk(n_log == 7, "R6 transaction count", n_log, 7);
    chk_log(6, 20'h102, 8'h00, "R6 sink pattern off on fail");
  endtask

  task automatic t_align_fail();
    wait_cyc = 16'd2; cr = 4'b0011; eq = 4'b0011; lk = 4'b0011; al = 1'b0;
    pulse_start();
    wait_end("R5 align");
    chk(fail && !done, "R5 alignment required", {done, fail}, 1);
  endtask

  task automatic t_sync_fail();
    wait_cyc = 16'd2; cr = 4'b0011; eq = 4'b0011; lk = 4'b0011; al = 1'b1;
    sink_stat = 8'h00;
    pulse_start();
    wait_end("R7 sync");
    chk(fail && !done, "R7 not in sync", {done, fail}, 1);
    chk(n_log == 8 && log_a[7] == 20'h205, "R7 status read before fail", n_log, 8);
    sink_stat = 8'h01;
  endtask

  task automatic t_busy_start();
    wait_cyc = 16'd4;
    pulse_start();
    repeat (12) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_end("R8 busy");
    chk(n_log == 8, "R8 start ignored while busy", n_log, 8);
    chk(done && !fail, "R8 done", {done, fail}, 2);
    repeat (20) @(negedge clk);
    chk(done && !fail, "R8 done holds", {done, fail}, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_nominal();
    t_one_lane();
    t_cr_fail();
    t_eq_fail();
    t_align_fail();
    t_sync_fail();
    t_busy_start();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule